// File: doc/BRIEF.md
# CAN Transceiver Mode and Protection Controller

This block sets the operating state of a high-speed CAN transceiver. Its inputs are the standby-select pin, the already-filtered undervoltage flags for the core supply and the I/O supply, an over-temperature flag, and a dominant time-out flag from a separate transmit monitor. From these it produces four controls:

- the driver enable and the dominant-drive command;
- the bus common-mode bias choice: mid-supply, ground, or no load;
- the receive-path choice: main receiver or low-power wake filter;
- the receive-pin value and its output enable.

When the select pin is low and no fault is present, the transceiver communicates. When the pin is high, the transceiver rests in low power, and the wake filter reports bus activity to the protocol controller. A supply fault overrides the select pin. When the fault clears, a recovery interval of a parameterised number of clock cycles must pass before normal operation can return. Every output is registered, so the outputs change on the same edge as the state register.

Top module: `xmc_mode_ctrl`

## Requirements
- R1: After reset the mode reads STANDBY (code 1), with driver off, ground bias (code 2), wake path selected (rx_sel 1) and receive pin enabled and high. An unconnected select pin is pulled high at the pad, so the default is standby.
- R2: With select low and no undervoltage, a NORMAL or STANDBY state moves to NORMAL (code 0) on the next edge. This gives mid-supply bias (code 1) and the main receiver path (rx_sel 0).
- R3: With select high and no undervoltage, a NORMAL or STANDBY state moves to STANDBY on the next edge. The driver is off, the bias is ground and the wake path is selected.
- R4: When the driver is enabled, the registered dominant command is the inverse of the transmit input. In any other mode the transmit input has no effect, and the dominant command stays 0.
- R5: Undervoltage on either supply gives FORCED_STANDBY (code 2) on the next edge, whatever the select pin is. The driver is off and the bias is ground.
- R6: With both supplies undervolted, the bias goes to no load (code 0).
- R7: I/O-supply undervoltage drops the receive-pin output enable and holds the receive value high, so wake activity is not passed.
- R8: Over-temperature turns the driver off and keeps mid-supply (recessive) bias in NORMAL. The driver returns on the edge after the flag clears.
- R9: The dominant time-out flag turns the driver off while it is set.
- R10: When all undervoltage flags are clear, FORCED_STANDBY moves to RECOVERY (code 3). RECOVERY lasts exactly RECOV_CYC cycles and then enters NORMAL or STANDBY according to the select pin. A new undervoltage during RECOVERY returns the state to FORCED_STANDBY, and the interval restarts.
- R11: The receive value follows the main receiver input in NORMAL and the wake filter input in every other mode, when the I/O supply is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_sel_i | input | 1 | Standby select, high requests low-power mode |
| txd_i | input | 1 | Transmit data, low requests dominant |
| uv_core_i | input | 1 | Core supply undervoltage flag |
| uv_io_i | input | 1 | I/O supply undervoltage flag |
| ot_i | input | 1 | Over-temperature flag |
| dom_to_i | input | 1 | Transmit dominant time-out flag |
| main_rx_i | input | 1 | Main receiver output, low when bus dominant |
| wake_rx_i | input | 1 | Wake filter output, low on a wake request |
| mode_o | output | 2 | State: 0 NORMAL, 1 STANDBY, 2 FORCED_STANDBY, 3 RECOVERY |
| drv_en_o | output | 1 | Driver enable |
| bus_dom_o | output | 1 | Drive dominant command |
| bias_o | output | 2 | Bias: 0 none, 1 mid-supply, 2 ground |
| rx_sel_o | output | 1 | Receive path: 0 main, 1 wake filter |
| rxd_o | output | 1 | Receive pin value |
| rxd_oe_o | output | 1 | Receive pin output enable |

## Verification
Two situations can fall in the same cycle. The first is the last cycle of the recovery interval together with a change of the select pin or a new undervoltage. The second is a thermal or time-out fault together with a supply fault. The bench provokes both with directed sequences timed to land on the exit cycle of recovery, and then with a long stretch of random inputs. A behavioural reference model, stepped on every edge, judges each output on every cycle.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL   = 2'd0,
      ST_STANDBY  = 2'd1,
      ST_FORCED   = 2'd2,
      ST_RECOVERY = 2'd3
   } xmc_state_e;

   typedef enum logic [1:0] {
      BIAS_NONE = 2'd0,
      BIAS_MID  = 2'd1,
      BIAS_GND  = 2'd2
   } xmc_bias_e;
endpackage

// File: rtl/xmc_state_fsm.sv
module xmc_state_fsm
   import xmc_pkg::*;
#(
   parameter int unsigned RECOV_CYC = 37500
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stby_sel,
   input  logic       uv_core,
   input  logic       uv_io,
   output xmc_state_e state_q,
   output xmc_state_e state_d
);
   localparam int unsigned CW = $clog2(RECOV_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(RECOV_CYC - 1);

   logic [CW-1:0] cnt_q, cnt_d;
   logic          uv_any;

   generate
      if (RECOV_CYC < 1) begin : g_bad_recov
         initial $fatal(1, "RECOV_CYC must be at least 1");
      end
   endgenerate

   assign uv_any = uv_core | uv_io;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      if (uv_any) begin
         state_d = ST_FORCED;
      end else begin
         unique case (state_q)
            ST_FORCED: begin
               state_d = ST_RECOVERY;
               cnt_d   = '0;
            end
            ST_RECOVERY: begin
               if (cnt_q == LAST) state_d = stby_sel ? ST_STANDBY : ST_NORMAL;
               else               cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = stby_sel ? ST_STANDBY : ST_NORMAL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_STANDBY;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   a_r5_uv_forces: assert property (@(posedge clk) disable iff (!rst_n)
      uv_any |=> state_q == ST_FORCED);
   a_r10_enter_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FORCED && !uv_any) |=> state_q == ST_RECOVERY);
   a_r10_window: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_RECOVERY |-> cnt_q < CW'(RECOV_CYC));
   a_r2_sel_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_NORMAL || state_q == ST_STANDBY) && !stby_sel && !uv_any)
      |=> state_q == ST_NORMAL);
endmodule

// File: rtl/xmc_out_decode.sv
module xmc_out_decode
   import xmc_pkg::*;
#(
   parameter bit RXD_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  xmc_state_e state_q,
   input  xmc_state_e state_d,
   input  logic       txd,
   input  logic       uv_core,
   input  logic       uv_io,
   input  logic       ot,
   input  logic       dom_to,
   input  logic       main_rx,
   input  logic       wake_rx,
   output logic [1:0] mode,
   output logic       drv_en,
   output logic       bus_dom,
   output logic [1:0] bias,
   output logic       rx_sel,
   output logic       rxd,
   output logic       rxd_oe
);
   logic      drv_d, nrm_d;
   xmc_bias_e bias_d;

   assign nrm_d = (state_d == ST_NORMAL);
   assign drv_d = nrm_d & ~ot & ~dom_to & ~uv_core & ~uv_io;

   always_comb begin
      if (nrm_d)                bias_d = BIAS_MID;
      else if (uv_core & uv_io) bias_d = BIAS_NONE;
      else                      bias_d = BIAS_GND;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= ST_STANDBY;
         drv_en  <= 1'b0;
         bus_dom <= 1'b0;
         bias    <= BIAS_GND;
         rx_sel  <= 1'b1;
         rxd_oe  <= 1'b1;
      end else begin
         mode    <= state_d;
         drv_en  <= drv_d;
         bus_dom <= drv_d & ~txd;
         bias    <= bias_d;
         rx_sel  <= ~nrm_d;
         rxd_oe  <= ~uv_io;
      end
   end

   generate
      if (RXD_REG) begin : g_rxd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rxd <= 1'b1;
            else        rxd <= uv_io | (nrm_d ? main_rx : wake_rx);
         end
      end else begin : g_rxd_comb
         assign rxd = uv_io | ((state_q == ST_NORMAL) ? main_rx : wake_rx);
      end
   endgenerate

   a_r9_timeout_off: assert property (@(posedge clk) disable iff (!rst_n)
      dom_to |=> !drv_en);
   a_r8_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
      ot |=> !drv_en);
   a_r7_io_uv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      uv_io |=> (!rxd_oe && rxd));
   a_r6_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_core && uv_io) |=> bias == BIAS_NONE);
   a_r4_idle_no_dom: assert property (@(posedge clk) disable iff (!rst_n)
      mode != ST_NORMAL |-> !bus_dom);
endmodule

// File: rtl/xmc_mode_ctrl.sv
module xmc_mode_ctrl
   import xmc_pkg::*;
#(
   parameter int unsigned RECOV_CYC = 37500,
   parameter bit          RXD_REG   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stby_sel_i,
   input  logic       txd_i,
   input  logic       uv_core_i,
   input  logic       uv_io_i,
   input  logic       ot_i,
   input  logic       dom_to_i,
   input  logic       main_rx_i,
   input  logic       wake_rx_i,
   output logic [1:0] mode_o,
   output logic       drv_en_o,
   output logic       bus_dom_o,
   output logic [1:0] bias_o,
   output logic       rx_sel_o,
   output logic       rxd_o,
   output logic       rxd_oe_o
);
   xmc_state_e st_q, st_d;

   xmc_state_fsm #(.RECOV_CYC(RECOV_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .stby_sel(stby_sel_i),
      .uv_core(uv_core_i), .uv_io(uv_io_i),
      .state_q(st_q), .state_d(st_d)
   );

   xmc_out_decode #(.RXD_REG(RXD_REG)) u_dec (
      .clk(clk), .rst_n(rst_n), .state_q(st_q), .state_d(st_d),
      .txd(txd_i), .uv_core(uv_core_i), .uv_io(uv_io_i), .ot(ot_i),
      .dom_to(dom_to_i), .main_rx(main_rx_i), .wake_rx(wake_rx_i),
      .mode(mode_o), .drv_en(drv_en_o), .bus_dom(bus_dom_o), .bias(bias_o),
      .rx_sel(rx_sel_o), .rxd(rxd_o), .rxd_oe(rxd_oe_o)
   );
endmodule

// File: tb/sim_xmc_mode_ctrl.sv
`timescale 1ns/1ps
module sim_xmc_mode_ctrl;
   localparam int RC = 20;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sel = 1'b1, txd = 1'b1, uvc = 1'b0, uvi = 1'b0, ot = 1'b0, dto = 1'b0;
   logic mrx = 1'b1, wrx = 1'b1;
   logic [1:0] mode, bias;
   logic drv, dom, rxsel, rxd, rxoe;

   int n_chk = 0, n_fail = 0, cyc = 0;
   string req = "R1";

   int m_st = 1, m_cnt = 0;
   int e_drv = 0, e_dom = 0, e_bias = 2, e_rxsel = 1, e_rxd = 1, e_rxoe = 1;

   always #4 clk = ~clk;

   xmc_mode_ctrl #(.RECOV_CYC(RC)) u0 (
      .clk(clk), .rst_n(rst_n), .stby_sel_i(sel), .txd_i(txd),
      .uv_core_i(uvc), .uv_io_i(uvi), .ot_i(ot), .dom_to_i(dto),
      .main_rx_i(mrx), .wake_rx_i(wrx), .mode_o(mode), .drv_en_o(drv),
      .bus_dom_o(dom), .bias_o(bias), .rx_sel_o(rxsel), .rxd_o(rxd),
      .rxd_oe_o(rxoe)
   );

   // behavioural reference: 0 normal, 1 standby, 2 forced, 3 recovery
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 1; m_cnt = 0;
         e_drv = 0; e_dom = 0; e_bias = 2; e_rxsel = 1; e_rxd = 1; e_rxoe = 1;
      end else begin
         if (uvc || uvi) m_st = 2;
         else if (m_st == 2) begin m_st = 3; m_cnt = 0; end
         else if (m_st == 3) begin
            m_cnt++;
            if (m_cnt == RC) m_st = sel ? 1 : 0;
         end else m_st = sel ? 1 : 0;
         e_drv   = (m_st == 0 && !ot && !dto) ? 1 : 0;
         e_dom   = (e_drv == 1 && txd == 1'b0) ? 1 : 0;
         e_bias  = (m_st == 0) ? 1 : ((uvc && uvi) ? 0 : 2);
         e_rxsel = (m_st == 0) ? 0 : 1;
         e_rxoe  = uvi ? 0 : 1;
         e_rxd   = uvi ? 1 : ((m_st == 0) ? int'(mrx) : int'(wrx));
      end
   end

   task automatic chk(string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      chk("mode", int'(mode), m_st);
      chk("drv_en", int'(drv), e_drv);
      chk("bus_dom", int'(dom), e_dom);
      chk("bias", int'(bias), e_bias);
      chk("rx_sel", int'(rxsel), e_rxsel);
      chk("rxd", int'(rxd), e_rxd);
      chk("rxd_oe", int'(rxoe), e_rxoe);
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      req = "R1";
      step(3);
      rst_n = 1'b1;
      step(3);
      req = "R2"; sel = 1'b0; step(3);
      req = "R11";
      for (int i = 0; i < 6; i++) begin mrx = i[0]; wrx = ~i[0]; step(1); end
      req = "R4";
      for (int i = 0; i < 6; i++) begin txd = i[1]; step(1); end
      txd = 1'b0;
      req = "R8"; ot = 1'b1; step(3); ot = 1'b0; step(2);
      req = "R9"; dto = 1'b1; step(3); dto = 1'b0; step(2);
      req = "R3"; sel = 1'b1; step(2);
      req = "R4";
      for (int i = 0; i < 4; i++) begin txd = i[0]; step(1); end
      req = "R11";
      for (int i = 0; i < 4; i++) begin wrx = i[0]; mrx = ~i[0]; step(1); end
      req = "R5"; sel = 1'b0; uvc = 1'b1; step(4);
      req = "R10"; uvc = 1'b0; step(RC + 4);
      req = "R10"; uvi = 1'b1; step(2); uvi = 1'b0; step(10);
      uvc = 1'b1; step(1); uvc = 1'b0; step(RC - 1);
      sel = 1'b1; step(4); sel = 1'b0; step(2);
      req = "R7"; uvi = 1'b1;
      for (int i = 0; i < 4; i++) begin wrx = i[0]; step(1); end
      req = "R6"; uvc = 1'b1; step(3); uvc = 1'b0; uvi = 1'b0; step(RC + 3);
      req = "R8"; ot = 1'b1; uvc = 1'b1; step(2); uvc = 1'b0; step(RC + 3); ot = 1'b0; step(3);
      req = "R10";
      for (int i = 0; i < 3000; i++) begin
         sel = ($urandom_range(0, 15) == 0) ? ~sel : sel;
         txd = 1'($urandom); mrx = 1'($urandom); wrx = 1'($urandom);
         ot  = ($urandom_range(0, 9) == 0);
         dto = ($urandom_range(0, 9) == 0);
         uvc = ($urandom_range(0, 60) == 0);
         uvi = ($urandom_range(0, 80) == 0);
         step(1);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule